// File: doc/BRIEF.md
# Spread-Spectrum Modulation Code Generator

This block produces the digital control word for a clock whose frequency is spread to lower its peak emissions. A 15-bit maximal-length shift register supplies a pseudorandom state. Its seven low bits drive a 128-level code, which a downstream converter maps linearly onto a window of ±10% around the nominal frequency. The register advances once every N cycles of the clock it modulates, and a three-way rate select chooses N as 16, 32 or 64. Each advance is announced by a one-cycle step strobe.

Modulation can be switched off in two ways. The first is an explicit force-off input. The second is a built-in activity detector, which sees when the rate-select input is being driven by a running clock rather than by a static level. While modulation is off, the code rests at mid-scale, no strobe is issued and the shift register keeps its state. When modulation resumes, the sequence continues from where it stopped.

Top module: `ssc_code_gen`

## Requirements
- R1: After reset the shift-register state equals the seed (default 1), so `code_o` reads 1 and `step_o` is low.
- R2: The rate select is decoded as follows: 0 gives N = 16, 1 gives N = 32, 2 gives N = 64, and 3 also gives N = 32. While modulation runs, consecutive `step_o` pulses are exactly N cycles apart.
- R3: At each step the state s becomes {s[13:0], s[14] XOR s[13]}. `code_o` equals bits [6:0] of the new state from the cycle after the strobe onward.
- R4: While modulation stays enabled, `code_o` changes only in the cycle after a strobe.
- R5: The code sequence repeats with a period of exactly 32767 steps.
- R6: While `force_off_i` is high, `code_o` is 64 and `step_o` stays low. A strobe that would fall in the cycle where force-off takes effect is suppressed. The state is held, and on release `code_o` shows the same code as before.
- R7: The detector counts changes of the sampled rate select over windows of 2N cycles. A window with more than N changes turns modulation off, with the same outputs as R6. A later window with at most N changes turns it back on, and the sequence continues unchanged.
- R8: A single change of the rate select does not turn modulation off. Stepping continues at the new spacing.
- R9: When modulation resumes, the first strobe falls in the N-th cycle, counting the cycle in which the enable returns as cycle 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock being modulated; one cycle per output period |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rate_sel_i | input | 2 | Rate select: 0 gives N=16, 1 gives N=32, 2 gives N=64, 3 gives N=32 |
| force_off_i | input | 1 | High forces the code to mid-scale and freezes the sequence |
| code_o | output | 7 | Modulation code, 0 to 127 |
| step_o | output | 1 | One-cycle strobe in the cycle before the code advances |

## Verification
Two functions can meet in a single cycle: a scheduled strobe and the moment force-off takes hold. The bench counts N−1 cycles after a strobe, so the prescaler is one edge away from its terminal count, and raises force-off just after that edge. It then expects no strobe in that cycle, the mid-scale code, and on release the code from before the stop, which proves the register did not advance. A second collision is a rate change landing mid-count. The bench judges it by requiring stepping to carry on without a stop, at the new spacing after the first strobe.

// File: rtl/ssc_pkg.sv
package ssc_pkg;

  typedef enum logic [1:0] {
    RATE_LOW   = 2'd0,
    RATE_MID   = 2'd1,
    RATE_HIGH  = 2'd2,
    RATE_SPARE = 2'd3
  } rate_sel_e;

  // Exponent offset added to the base shift: 0 -> N base, 1 -> 2x, 2 -> 4x.
  function automatic logic [1:0] rate_exp(input logic [1:0] sel);
    logic [1:0] e;
    case (sel)
      RATE_LOW:  e = 2'd0;
      RATE_HIGH: e = 2'd2;
      default:   e = 2'd1;
    endcase
    return e;
  endfunction

endpackage

// File: rtl/ssc_activity_det.sv
module ssc_activity_det
  import ssc_pkg::*;
#(
  parameter int unsigned SHIFT_LO = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] sel_i,
  output logic [1:0] exp_o,
  output logic       busy_o
);

  localparam int unsigned WIN_W = SHIFT_LO + 4;

  logic [1:0]       samp_q, prev_q;
  logic [1:0]       lat_q, lat_d;
  logic [WIN_W-1:0] win_q, win_d;
  logic [WIN_W-1:0] edge_q, edge_d;
  logic             busy_q, busy_d;
  logic [WIN_W-1:0] win_last;
  logic [WIN_W-1:0] half_len;
  logic [WIN_W-1:0] edge_sum;
  logic             chg;
  logic             win_end;

  always_comb begin
    chg      = (samp_q != prev_q);
    half_len = WIN_W'(1) << (SHIFT_LO + lat_q);
    win_last = (half_len << 1) - WIN_W'(1);
    edge_sum = edge_q + WIN_W'(chg);
    win_end  = (win_q == win_last);
    lat_d    = lat_q;
    busy_d   = busy_q;
    if (win_end) begin
      win_d  = '0;
      edge_d = '0;
      busy_d = (edge_sum > half_len);
      lat_d  = rate_exp(samp_q);
    end else begin
      win_d  = win_q + WIN_W'(1);
      edge_d = edge_sum;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      samp_q <= '0;
      prev_q <= '0;
      lat_q  <= '0;
      win_q  <= '0;
      edge_q <= '0;
      busy_q <= 1'b0;
    end else begin
      samp_q <= sel_i;
      prev_q <= samp_q;
      lat_q  <= lat_d;
      win_q  <= win_d;
      edge_q <= edge_d;
      busy_q <= busy_d;
    end
  end

  assign exp_o  = rate_exp(samp_q);
  assign busy_o = busy_q;

  // R7: the window position never runs past the latched window length
  p_window_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_q <= win_last);

  // R7: the busy flag only moves at a window boundary
  p_busy_at_edge_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q != $past(busy_q)) |-> ($past(win_q) == $past(win_last)));

endmodule

// File: rtl/ssc_prescaler.sv
module ssc_prescaler #(
  parameter int unsigned SHIFT_LO = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic [1:0] exp_i,
  output logic       tick_o
);

  localparam int unsigned CNT_W = SHIFT_LO + 2;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W:0]   span;
  logic [CNT_W-1:0] last;
  logic             tick;

  always_comb begin
    span = (CNT_W+1)'(1) << (SHIFT_LO + exp_i);
    last = CNT_W'(span - (CNT_W+1)'(1));
    tick = run_i && (cnt_q >= last);
    if (!run_i || tick) cnt_d = '0;
    else                cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign tick_o = tick;

  // R2: with N of at least 2, strobes are never back to back
  p_tick_gap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);

  // R9: the first enabled cycle after a stop never strobes
  p_resume_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(!run_i) && run_i) |-> !tick_o);

endmodule

// File: rtl/ssc_lfsr.sv
module ssc_lfsr #(
  parameter int unsigned   W    = 15,
  parameter int unsigned   TAP  = 13,
  parameter logic [W-1:0]  SEED = W'(1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         adv_i,
  output logic [W-1:0] state_o
);

  logic [W-1:0] state_q, state_d;
  logic         fb;

  always_comb begin
    fb      = state_q[W-1] ^ state_q[TAP];
    state_d = adv_i ? {state_q[W-2:0], fb} : state_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SEED;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  // R5: a maximal-length register never reaches the all-zero lock state
  p_nonzero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != '0);

  // R6: without an advance request the state is frozen
  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(state_q));

  // R3: an advance shifts the register up by one place
  p_shift_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |=> (state_q[W-1:1] == $past(state_q[W-2:0])));

endmodule

// File: rtl/ssc_code_gen.sv
module ssc_code_gen #(
  parameter int unsigned        SHIFT_LO = 4,
  parameter int unsigned        LFSR_W   = 15,
  parameter int unsigned        LFSR_TAP = 13,
  parameter int unsigned        CODE_W   = 7,
  parameter logic [LFSR_W-1:0]  SEED     = LFSR_W'(1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        rate_sel_i,
  input  logic              force_off_i,
  output logic [CODE_W-1:0] code_o,
  output logic              step_o
);

  localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(1) << (CODE_W - 1);

  logic [1:0]        rst_sync_q;
  logic              rst_n;
  logic [1:0]        rate_exp;
  logic              busy;
  logic              mod_en;
  logic              tick;
  logic [LFSR_W-1:0] state;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  ssc_activity_det #(.SHIFT_LO(SHIFT_LO)) u_det (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .sel_i  (rate_sel_i),
    .exp_o  (rate_exp),
    .busy_o (busy)
  );

  assign mod_en = !(busy || force_off_i);

  ssc_prescaler #(.SHIFT_LO(SHIFT_LO)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .run_i  (mod_en),
    .exp_i  (rate_exp),
    .tick_o (tick)
  );

  ssc_lfsr #(.W(LFSR_W), .TAP(LFSR_TAP), .SEED(SEED)) u_lfsr (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .adv_i   (tick),
    .state_o (state)
  );

  always_comb begin
    code_o = mod_en ? state[CODE_W-1:0] : MID_CODE;
    step_o = tick;
  end

  // R4: with modulation enabled across a cycle, the code moves only after a strobe
  p_code_steady_r4: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!$past(step_o) && $past(mod_en) && mod_en) |-> $stable(code_o));

  // R6: no strobe leaves the block while modulation is off
  p_quiet_when_off_r6: assert property (@(posedge clk_i) disable iff (!rst_n)
    !mod_en |-> !step_o);

endmodule

// File: tb/ssc_code_gen_bench.sv
module ssc_code_gen_bench;

  logic       clk;
  logic       rst_ni;
  logic [1:0] rate_sel;
  logic       force_off;
  logic [6:0] code;
  logic       step;
  logic [6:0] f_code;
  logic       f_step;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [14:0] model;
  logic [6:0]  exp_code;
  int          code_err;

  // fast copy (N = 2 at rate 0) used for the period check
  logic [14:0] f_model;
  logic [6:0]  f_first [1:64];
  int          f_steps;
  int          f_rep_err;
  int          f_mod_err;
  bit          f_pend;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  ssc_code_gen u_ssc_code_gen (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .rate_sel_i  (rate_sel),
    .force_off_i (force_off),
    .code_o      (code),
    .step_o      (step)
  );

  ssc_code_gen #(.SHIFT_LO(1)) u_ssc_code_gen_fast (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .rate_sel_i  (2'd0),
    .force_off_i (1'b0),
    .code_o      (f_code),
    .step_o      (f_step)
  );

  function automatic logic [14:0] adv(input logic [14:0] s);
    return {s[13:0], s[14] ^ s[13]};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // One cycle: sample at the falling edge, compare the code, then track strobes.
  task automatic cyc();
    @(negedge clk);
    exp_code = model[6:0];
    if (code != exp_code && force_off == 1'b0 && code != 7'd64) code_err++;
    if (step) model = adv(model);
  endtask

  always @(negedge clk) begin
    if (!rst_ni) begin
      f_model   <= 15'd1;
      f_steps   <= 0;
      f_rep_err <= 0;
      f_mod_err <= 0;
      f_pend    <= 1'b0;
    end else begin
      if (f_pend) begin
        if (f_code != f_model[6:0]) f_mod_err <= f_mod_err + 1;
        if (f_steps <= 64) f_first[f_steps] <= f_code;
        else if (f_steps > 32767 && f_steps <= 32767 + 64)
          if (f_code != f_first[f_steps - 32767]) f_rep_err <= f_rep_err + 1;
      end
      f_pend <= f_step;
      if (f_step) begin
        f_model <= adv(f_model);
        f_steps <= f_steps + 1;
      end
    end
  end

  task automatic t_reset();
    rst_ni    = 1'b0;
    rate_sel  = 2'd0;
    force_off = 1'b0;
    model     = 15'd1;
    code_err  = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(code == 7'd1, "R1 code in reset", code, 1);
    chk(step == 1'b0, "R1 strobe in reset", step, 0);
    rst_ni = 1'b1;
    repeat (4) cyc();
    chk(code == 7'd1, "R1 code after reset release", code, 1);
  endtask

  task automatic t_spacing(input logic [1:0] rs, input int n);
    int gap;
    int wait_n;
    int err0;
    err0 = code_err;
    rate_sel = rs;
    cyc(); cyc();
    wait_n = 0;
    do begin cyc(); wait_n++; end while (!step && wait_n < 200);
    chk(wait_n <= 2 * 64 + 2, "R8 stepping continues after rate change", wait_n, n);
    for (int k = 0; k < 3; k++) begin
      gap = 0;
      do begin cyc(); gap++; end while (!step && gap < 200);
      chk(gap == n, "R2 strobe spacing", gap, n);
    end
    cyc();
    chk(code_err == err0, "R3 R4 code follows recurrence", code_err - err0, 0);
  endtask

  task automatic t_force_off();
    int n;
    int bad_step;
    int bad_code;
    logic [6:0] c0;
    rate_sel = 2'd0;
    repeat (40) cyc();
    n = 0;
    do begin cyc(); n++; end while (!step && n < 200);
    repeat (15) cyc();
    c0 = code;
    @(posedge clk); #1 force_off = 1'b1;
    cyc();
    chk(step == 1'b0, "R6 strobe suppressed in colliding cycle", step, 0);
    chk(code == 7'd64, "R6 mid-scale code", code, 64);
    bad_step = 0;
    bad_code = 0;
    for (int k = 0; k < 150; k++) begin
      cyc();
      if (step) bad_step++;
      if (code != 7'd64) bad_code++;
    end
    chk(bad_step == 0, "R6 no strobe while forced off", bad_step, 0);
    chk(bad_code == 0, "R6 code held at 64", bad_code, 0);
    @(posedge clk); #1 force_off = 1'b0;
    n = 0;
    do begin
      cyc();
      n++;
      if (n == 1) chk(code == c0, "R6 code resumes unchanged", code, c0);
    end while (!step && n < 200);
    chk(n == 16, "R9 first strobe after resume", n, 16);
  endtask

  task automatic t_activity();
    int bad_step;
    int bad_code;
    int steps;
    int err0;
    err0 = code_err;
    bad_step = 0;
    bad_code = 0;
    for (int k = 0; k < 400; k++) begin
      cyc();
      rate_sel = (rate_sel == 2'd0) ? 2'd2 : 2'd0;
      if (k >= 250) begin
        if (step) bad_step++;
        if (code != 7'd64) bad_code++;
      end
    end
    chk(bad_step == 0, "R7 toggling select stops strobes", bad_step, 0);
    chk(bad_code == 0, "R7 toggling select gives mid-scale", bad_code, 0);
    rate_sel = 2'd0;
    repeat (300) cyc();
    steps = 0;
    for (int k = 0; k < 100; k++) begin
      cyc();
      if (step) steps++;
    end
    chk(steps >= 5 && steps <= 7, "R7 stepping resumes when select is static", steps, 6);
    chk(code_err == err0, "R7 sequence continues after detector release", code_err - err0, 0);
  endtask

  task automatic t_period();
    while (f_steps < 32767 + 66) cyc();
    chk(f_mod_err == 0, "R3 fast copy follows recurrence", f_mod_err, 0);
    chk(f_rep_err == 0, "R5 sequence repeats after 32767 steps", f_rep_err, 0);
    chk(f_first[1] != f_first[2] || f_first[2] != f_first[3], "R5 sequence not constant",
        f_first[1], f_first[2]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_spacing(2'd0, 16);
    t_spacing(2'd1, 32);
    t_spacing(2'd2, 64);
    t_spacing(2'd3, 32);
    t_force_off();
    t_activity();
    t_period();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule